// File: doc/BRIEF.md
# Right Line Register Remapping Decoder

This block sits on the host side of an audio mixer's indexed control space. The host presents a write as an index, a page flag that selects the base or the extended page, and a data byte. Most indices are of no interest here. The decoder owns five registers: the base source-select register (index 1), the base right-line control register (index 19), and the extended registers 1 (remapped right-line volume), 7 (internal FM synthesizer) and 17 (wavetable synthesizer).

Two synthesizer remap conditions can take over base index 19. While the FM synthesizer remap is active, writes and reads of that index go to extended register 7. While the wavetable remap is active, they go to extended register 17. FM wins if both are active. While either remap is active, the right-line gain and mutes are taken from extended register 1 instead of index 19. The effective mutes also depend on the operating mode. In the full mode (mode 3), the bypass and input-mixer mute bits are honoured. In the legacy modes, the bypass mute follows the source select and the input mute is forced on.

The write port is a valid/ready stream that never applies back-pressure. `wr_ready` is high in every cycle after reset is released, so a write is taken in each cycle where `wr_valid` is high. A write takes effect at the next rising edge. The read port and the line outputs are combinational views of the stored registers, the mode and the enable bits.

Top module: `rline_remap_dec`

## Requirements
- R1: After reset every owned register reads 0x00. With mode 3 and no remap, `rl_gain` is 0 and all three mutes are 0.
- R2: With no remap active, a base-page write to index 19 updates the right-line control register, and a base-page read of index 19 returns it.
- R3: FM remap is active when `fm_en`=1 and `fm_remap`=1. While it is active, a base write to index 19 goes to extended register 7 and leaves the base index 19 register unchanged, and a base read of index 19 returns extended register 7.
- R4: Wavetable remap is active when `wt_en`=1 and `wt_remap_dis`=0. When FM remap is not active, base writes and reads of index 19 go to extended register 17.
- R5: When both remaps are active, a base write to index 19 updates only extended register 7, and extended register 17 is unchanged.
- R6: The line control byte is extended register 1 when either remap is active, and base index 19 otherwise. `rl_gain` is bits [4:0] of that byte, and `rl_mute_out` is bit 7 of it in every mode.
- R7: In mode 3, `rl_mute_bypass` equals bit 6 of the line control byte and `rl_mute_in` equals bit 5.
- R8: In modes 0, 1 and 2, `rl_mute_bypass` is 1 unless the source-select field (bits [7:6] of base index 1) equals 2'b01. Bit 6 of the line control byte has no effect.
- R9: In modes 0, 1 and 2, `rl_mute_in` is 1 regardless of bit 5 of the line control byte.
- R10: Extended-page writes to indices 1, 7 and 17 reach those registers directly, whatever the remap state. Extended-page reads return them.
- R11: A write to any index the block does not own changes no owned register. Reads of such indices return 0x00.
- R12: `wr_ready` is 1 in every cycle after reset. A write with `wr_valid`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (always 1 after reset) |
| wr_ext | input | 1 | Write page: 0 base, 1 extended |
| wr_index | input | 5 | Write index |
| wr_data | input | 8 | Write data |
| rd_ext | input | 1 | Read page: 0 base, 1 extended |
| rd_index | input | 5 | Read index |
| rd_data | output | 8 | Read data |
| mode | input | 2 | Operating mode (3 = full) |
| fm_en | input | 1 | Internal FM synthesizer enable |
| fm_remap | input | 1 | FM remap request |
| wt_en | input | 1 | Wavetable synthesizer enable |
| wt_remap_dis | input | 1 | Wavetable remap disable |
| rl_gain | output | 5 | Effective right-line gain code |
| rl_mute_bypass | output | 1 | Effective bypass-path mute |
| rl_mute_in | output | 1 | Effective input-mixer mute |
| rl_mute_out | output | 1 | Effective output-mixer mute |

## Verification
A write is stored at the rising edge where `wr_valid` and `wr_ready` are both high. Readback and line outputs reflect it from that edge on. The bench therefore drives a write on a falling edge and holds it across one rising edge. It checks on the next falling edge, after the read inputs have settled. Mode, enable and read-address changes act combinationally, so the bench checks them a short delay after it drives them, without waiting for a clock edge. Register contents are compared after each write against a bench model that routes the write the way the requirements say.

// File: rtl/rlr_pkg.sv
package rlr_pkg;
  typedef enum int unsigned {
    REG_SRC  = 0,
    REG_LINE = 1,
    REG_XVOL = 2,
    REG_XFM  = 3,
    REG_XWT  = 4
  } reg_id_e;

  localparam int unsigned NREG = 5;
  localparam int unsigned FULL_MODE = 3;
endpackage

// File: rtl/rlr_route.sv
module rlr_route import rlr_pkg::*; #(
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned IDX_SRC   = 1,
  parameter int unsigned IDX_LINE  = 19,
  parameter int unsigned XIDX_VOL  = 1,
  parameter int unsigned XIDX_FM   = 7,
  parameter int unsigned XIDX_WT   = 17
) (
  input  logic             fire,
  input  logic             ext,
  input  logic [IDX_W-1:0] index,
  input  logic             fm_act,
  input  logic             wt_act,
  output logic [NREG-1:0]  sel
);
  always_comb begin
    sel = '0;
    if (fire) begin
      if (!ext) begin
        if (index == IDX_W'(IDX_SRC)) begin
          sel[REG_SRC] = 1'b1;
        end else if (index == IDX_W'(IDX_LINE)) begin
          if (fm_act)      sel[REG_XFM]  = 1'b1;
          else if (wt_act) sel[REG_XWT]  = 1'b1;
          else             sel[REG_LINE] = 1'b1;
        end
      end else begin
        if (index == IDX_W'(XIDX_VOL))     sel[REG_XVOL] = 1'b1;
        else if (index == IDX_W'(XIDX_FM)) sel[REG_XFM]  = 1'b1;
        else if (index == IDX_W'(XIDX_WT)) sel[REG_XWT]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rlr_regfile.sv
module rlr_regfile import rlr_pkg::*; #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREG-1:0]               we,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NREG-1:0]               rsel,
  output logic [DATA_W-1:0]             rdata,
  output logic [NREG-1:0][DATA_W-1:0]   regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)     regs[g] <= '0;
      else if (we[g]) regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rsel[i]) rdata = rdata | regs[i];
    end
  end
endmodule

// File: rtl/rlr_linectl.sv
module rlr_linectl import rlr_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GAIN_W = 5
) (
  input  logic              remap_act,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] base_line,
  input  logic [DATA_W-1:0] ext_vol,
  input  logic [1:0]        src_sel,
  output logic [GAIN_W-1:0] gain,
  output logic              mute_bypass,
  output logic              mute_in,
  output logic              mute_out
);
  localparam int unsigned BIT_OUT = DATA_W - 1;
  localparam int unsigned BIT_BYP = DATA_W - 2;
  localparam int unsigned BIT_IN  = DATA_W - 3;
  localparam logic [1:0]  SRC_LINE = 2'b01;

  logic [DATA_W-1:0] line;
  logic              full;

  assign line = remap_act ? ext_vol : base_line;
  assign full = (mode == 2'(FULL_MODE));

  assign gain        = line[GAIN_W-1:0];
  assign mute_out    = line[BIT_OUT];
  assign mute_bypass = full ? line[BIT_BYP] : (src_sel != SRC_LINE);
  assign mute_in     = full ? line[BIT_IN] : 1'b1;
endmodule

// File: rtl/rline_remap_dec.sv
module rline_remap_dec import rlr_pkg::*; #(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned GAIN_W   = 5,
  parameter int unsigned IDX_SRC  = 1,
  parameter int unsigned IDX_LINE = 19,
  parameter int unsigned XIDX_VOL = 1,
  parameter int unsigned XIDX_FM  = 7,
  parameter int unsigned XIDX_WT  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_ext,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ext,
  input  logic [IDX_W-1:0]  rd_index,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        mode,
  input  logic              fm_en,
  input  logic              fm_remap,
  input  logic              wt_en,
  input  logic              wt_remap_dis,
  output logic [GAIN_W-1:0] rl_gain,
  output logic              rl_mute_bypass,
  output logic              rl_mute_in,
  output logic              rl_mute_out
);
  logic                        fm_act, wt_act, wr_fire;
  logic [NREG-1:0]             we, rsel;
  logic [NREG-1:0][DATA_W-1:0] regs;

  assign fm_act   = fm_en & fm_remap;
  assign wt_act   = wt_en & ~wt_remap_dis;
  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready;

  rlr_route #(
    .IDX_W(IDX_W), .IDX_SRC(IDX_SRC), .IDX_LINE(IDX_LINE),
    .XIDX_VOL(XIDX_VOL), .XIDX_FM(XIDX_FM), .XIDX_WT(XIDX_WT)
  ) u_wr_route (
    .fire(wr_fire), .ext(wr_ext), .index(wr_index),
    .fm_act(fm_act), .wt_act(wt_act), .sel(we)
  );

  rlr_route #(
    .IDX_W(IDX_W), .IDX_SRC(IDX_SRC), .IDX_LINE(IDX_LINE),
    .XIDX_VOL(XIDX_VOL), .XIDX_FM(XIDX_FM), .XIDX_WT(XIDX_WT)
  ) u_rd_route (
    .fire(1'b1), .ext(rd_ext), .index(rd_index),
    .fm_act(fm_act), .wt_act(wt_act), .sel(rsel)
  );

  rlr_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .wdata(wr_data),
    .rsel(rsel), .rdata(rd_data), .regs(regs)
  );

  rlr_linectl #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_line (
    .remap_act(fm_act | wt_act), .mode(mode),
    .base_line(regs[REG_LINE]), .ext_vol(regs[REG_XVOL]),
    .src_sel(regs[REG_SRC][DATA_W-1 -: 2]),
    .gain(rl_gain), .mute_bypass(rl_mute_bypass),
    .mute_in(rl_mute_in), .mute_out(rl_mute_out)
  );
endmodule

// File: rtl/rlr_checker.sv
module rlr_checker import rlr_pkg::*; #(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDX_SRC  = 1,
  parameter int unsigned IDX_LINE = 19,
  parameter int unsigned XIDX_VOL = 1,
  parameter int unsigned XIDX_FM  = 7,
  parameter int unsigned XIDX_WT  = 17
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_valid,
  input logic                        wr_ready,
  input logic                        wr_ext,
  input logic [IDX_W-1:0]            wr_index,
  input logic [DATA_W-1:0]           wr_data,
  input logic [1:0]                  mode,
  input logic                        fm_en,
  input logic                        fm_remap,
  input logic                        wt_en,
  input logic                        wt_remap_dis,
  input logic                        rl_mute_in,
  input logic [NREG-1:0][DATA_W-1:0] regs
);
  logic base_line_wr, owned;
  assign base_line_wr = wr_valid && wr_ready && !wr_ext && wr_index == IDX_W'(IDX_LINE);
  assign owned = wr_ext ? (wr_index == IDX_W'(XIDX_VOL) || wr_index == IDX_W'(XIDX_FM) ||
                           wr_index == IDX_W'(XIDX_WT))
                        : (wr_index == IDX_W'(IDX_SRC) || wr_index == IDX_W'(IDX_LINE));

  assert_ready_R12: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);

  assert_fm_steer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (base_line_wr && fm_en && fm_remap) |=>
      (regs[REG_XFM] == $past(wr_data)) && $stable(regs[REG_LINE]));

  assert_fm_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (base_line_wr && fm_en && fm_remap && wt_en && !wt_remap_dis) |=> $stable(regs[REG_XWT]));

  assert_wt_steer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (base_line_wr && !(fm_en && fm_remap) && wt_en && !wt_remap_dis) |=>
      (regs[REG_XWT] == $past(wr_data)) && $stable(regs[REG_LINE]));

  assert_unowned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !owned) |=> $stable(regs));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(regs));

  assert_in_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'(FULL_MODE)) |-> rl_mute_in);
endmodule

bind rline_remap_dec rlr_checker #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .IDX_SRC(IDX_SRC), .IDX_LINE(IDX_LINE),
  .XIDX_VOL(XIDX_VOL), .XIDX_FM(XIDX_FM), .XIDX_WT(XIDX_WT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_ext(wr_ext), .wr_index(wr_index), .wr_data(wr_data), .mode(mode),
  .fm_en(fm_en), .fm_remap(fm_remap), .wt_en(wt_en), .wt_remap_dis(wt_remap_dis),
  .rl_mute_in(rl_mute_in), .regs(regs)
);

// File: tb/rline_remap_dec_tb.sv
module rline_remap_dec_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_ready, wr_ext = 1'b0;
  logic [4:0] wr_index = '0;
  logic [7:0] wr_data = '0;
  logic       rd_ext = 1'b0;
  logic [4:0] rd_index = '0;
  logic [7:0] rd_data;
  logic [1:0] mode = 2'd3;
  logic       fm_en = 0, fm_remap = 0, wt_en = 0, wt_remap_dis = 0;
  logic [4:0] rl_gain;
  logic       rl_mute_bypass, rl_mute_in, rl_mute_out;

  int checks = 0, errors = 0;
  logic [7:0] m_src = 0, m_line = 0, m_xvol = 0, m_xfm = 0, m_xwt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rline_remap_dec u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_ext(wr_ext), .wr_index(wr_index), .wr_data(wr_data),
    .rd_ext(rd_ext), .rd_index(rd_index), .rd_data(rd_data),
    .mode(mode), .fm_en(fm_en), .fm_remap(fm_remap), .wt_en(wt_en),
    .wt_remap_dis(wt_remap_dis), .rl_gain(rl_gain), .rl_mute_bypass(rl_mute_bypass),
    .rl_mute_in(rl_mute_in), .rl_mute_out(rl_mute_out)
  );

  function automatic bit fm_on(); return fm_en && fm_remap; endfunction
  function automatic bit wt_on(); return wt_en && !wt_remap_dis; endfunction

  function automatic logic [7:0] exp_read(bit ext, logic [4:0] idx);
    if (!ext) begin
      if (idx == 1) return m_src;
      if (idx == 19) return fm_on() ? m_xfm : (wt_on() ? m_xwt : m_line);
      return 8'h00;
    end
    if (idx == 1) return m_xvol;
    if (idx == 7) return m_xfm;
    if (idx == 17) return m_xwt;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_line();
    return (fm_on() || wt_on()) ? m_xvol : m_line;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_read(string req, bit ext, logic [4:0] idx);
    rd_ext = ext; rd_index = idx; #1;
    check(req, rd_data, exp_read(ext, idx));
  endtask

  task automatic check_all_reads(string req);
    check_read(req, 0, 1); check_read(req, 0, 19);
    check_read(req, 1, 1); check_read(req, 1, 7); check_read(req, 1, 17);
  endtask

  task automatic check_line(string req);
    logic [7:0] l;
    bit full;
    #1;
    l = exp_line();
    full = (mode == 2'd3);
    check({req, " gain R6"}, {3'b0, rl_gain}, {3'b0, l[4:0]});
    check({req, " out R6"}, {7'b0, rl_mute_out}, {7'b0, l[7]});
    check({req, full ? " byp R7" : " byp R8"}, {7'b0, rl_mute_bypass},
          {7'b0, full ? l[6] : (m_src[7:6] != 2'b01)});
    check({req, full ? " in R7" : " in R9"}, {7'b0, rl_mute_in}, {7'b0, full ? l[5] : 1'b1});
  endtask

  task automatic do_write(bit ext, logic [4:0] idx, logic [7:0] d, bit valid = 1);
    wr_ext = ext; wr_index = idx; wr_data = d; wr_valid = valid;
    @(posedge clk);
    if (valid) begin
      checks++;
      if (wr_ready !== 1'b1) begin errors++; $display("FAIL R12 actual=%b expected=1", wr_ready); end
      if (!ext) begin
        if (idx == 1) m_src = d;
        else if (idx == 19) begin
          if (fm_on()) m_xfm = d; else if (wt_on()) m_xwt = d; else m_line = d;
        end
      end else begin
        if (idx == 1) m_xvol = d; else if (idx == 7) m_xfm = d; else if (idx == 17) m_xwt = d;
      end
    end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic set_en(bit a, bit b, bit c, bit d);
    fm_en = a; fm_remap = b; wt_en = c; wt_remap_dis = d;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1237));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_all_reads("R1");
    check_line("R1");

    // R2 plain write
    do_write(0, 19, 8'hA3); check_all_reads("R2"); check_line("R2");

    // R3 FM remap
    set_en(1, 1, 0, 0);
    do_write(0, 19, 8'h5C); check_read("R3", 0, 19); check_read("R3", 1, 7);
    set_en(0, 0, 0, 1); check_read("R3 base kept", 0, 19);

    // R4 wavetable remap
    set_en(0, 0, 1, 0);
    do_write(0, 19, 8'h3E); check_read("R4", 0, 19); check_read("R4", 1, 17);

    // R5 both active: FM wins
    set_en(1, 1, 1, 0);
    do_write(0, 19, 8'h77); check_all_reads("R5");
    set_en(0, 0, 1, 0); check_read("R5 wt kept", 0, 19);

    // R10 direct extended writes; R6 volume from extended 1 while remapped
    do_write(1, 1, 8'hE9); do_write(1, 7, 8'h12); do_write(1, 17, 8'h34);
    check_all_reads("R10"); check_line("R6 remap");
    set_en(0, 0, 0, 0); check_line("R6 base");

    // R8 / R9 legacy modes with source select
    for (int m = 0; m < 3; m++) begin
      mode = 2'(m);
      do_write(0, 1, 8'h40); check_line("R8 line");
      do_write(0, 1, 8'hC0); check_line("R8 other");
    end
    mode = 3; do_write(0, 19, 8'h60); check_line("R7");
    mode = 1; check_line("R9");

    // R11 unowned index, R12 idle write
    mode = 3;
    do_write(0, 5, 8'hFF); check_all_reads("R11"); check_read("R11", 0, 5);
    do_write(1, 19, 8'hFF); check_all_reads("R11"); check_read("R11", 1, 19);
    do_write(0, 19, 8'hFF, 0); check_all_reads("R12");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [4:0] idx;
      bit ext;
      int pick;
      set_en($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      mode = 2'($urandom_range(0, 3));
      pick = $urandom_range(0, 5);
      case (pick)
        0: begin ext = 0; idx = 1; end
        1, 2: begin ext = 0; idx = 19; end
        3: begin ext = 1; idx = 1; end
        4: begin ext = 1; idx = (i % 2) ? 5'd7 : 5'd17; end
        default: begin ext = $urandom_range(0, 1); idx = 5'($urandom_range(0, 31)); end
      endcase
      do_write(ext, idx, 8'($urandom_range(0, 255)), $urandom_range(0, 7) != 0);
      check_all_reads("R2 R3 R4 R5 R10 R11 random");
      check_line("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule